// File: doc/BRIEF.md
# ADC Serial Command and Register Access Engine

This block turns a simple host request into a complete SPI transaction toward a multi-channel delta-sigma converter. A request is one of three kinds. A bare command sends a single opcode byte. A register read forms a read opcode from a 5-bit address, sends a count byte of zero, pauses for the converter's decode time and then clocks in one data byte. A register write sends the write opcode, the zero count byte, the same decode pause and finally the value byte.

The engine drives chip-select, the serial clock and the outgoing data line in SPI mode 1 (clock idles low, data launched on the rising edge and captured on the falling edge, most significant bit first). Every pause is timed in converter clock periods, which are derived from the system clock by a parameterised ratio. A reset command also keeps the engine busy for the converter's recovery time after chip-select rises. The host sees `busy` for the whole transaction and a one-cycle `done` at its end. Read data is held on `rdData` after `done`.

Top module: `spi_adc_cmd_engine`

## Requirements
- R1: A command request (kind 2'b00) produces one frame of exactly one byte equal to `reqCmd`, sent MSB first and launched on rising SCLK edges.
- R2: A read request (kind 2'b01) sends 8'h20 OR-ed with `reqAddr`, then 8'h00, then clocks in a third byte that appears on `rdData` once `done` is seen.
- R3: A write request (kind 2'b10) sends 8'h40 OR-ed with `reqAddr`, then 8'h00, then `reqWrData`, all in one frame.
- R4: In a read or write, at least 4 converter clock periods (4 × ADC_RATIO system cycles) pass between the last falling SCLK edge of the second byte and the first rising SCLK edge of the third.
- R5: After the command byte 8'h06 the engine holds `busy` and withholds `done` for at least 18 converter clock periods after chip-select rises.
- R6: Chip-select stays low from the first bit to the last bit of a request, decode pause included, and is high before `done` rises; SCLK is low whenever chip-select is high.
- R7: `busy` is high from the cycle after a request is taken until `done`; `done` lasts one cycle and `busy` is low in the next cycle.
- R8: A request presented while `busy` is high, including the cycle in which `done` is high, starts no frame and does not change the frame in progress.
- R9: Commands other than 8'h06 raise `done` fewer than 18 converter clock periods after chip-select rises.
- R10: Out of reset, chip-select is high, SCLK is low, and `busy` and `done` are low.
- R11: A request of kind 2'b11 is not taken: no frame starts and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqKind | input | 2 | 00 command, 01 register read, 10 register write, 11 not taken |
| reqCmd | input | 8 | Command byte for kind 00 |
| reqAddr | input | 5 | Register address for read and write |
| reqWrData | input | 8 | Value for a register write |
| busy | output | 1 | High while a request is in flight |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte returned by the last register read |
| csN | output | 1 | SPI chip-select, active low |
| sclk | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | SPI data toward the converter |
| miso | input | 1 | SPI data from the converter |

## Verification
Completion and request acceptance are the two functions that can land in the same cycle: the host may see `done` and present its next request right then. The bench waits for `done` at a falling clock edge and raises `reqValid` in that very cycle. It then judges the result over a quiet window: no new chip-select frame may appear and `busy` must return low. A second collision is made mid-frame, where a read is offered during a write and the write bytes must come out untouched.

// File: rtl/spi_adc_cmd_pkg.sv
package spi_adc_cmd_pkg;

  localparam int REG_ADDR_W = 5;
  localparam logic [7:0] RESET_OPCODE = 8'h06;
  localparam logic [2:0] READ_PREFIX  = 3'b001;
  localparam logic [2:0] WRITE_PREFIX = 3'b010;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } reqKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       csAssert;
    logic       csRelease;
    logic       loadByte;
    logic [7:0] txByte;
    logic       waitStart;
    logic       waitLong;   // 1: post-reset recovery, 0: decode pause
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic       byteDone;
    logic       waitDone;
    logic [7:0] rxByte;
  } dpStatus_t;

endpackage

// File: rtl/spi_adc_cmd_dp.sv
module spi_adc_cmd_dp
  import spi_adc_cmd_pkg::*;
#(
  parameter int SCLK_HALF   = 2,
  parameter int ADC_RATIO   = 3,
  parameter int DECODE_WAIT = 4,
  parameter int RESET_WAIT  = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  output dpStatus_t   dpStat,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);

  localparam int DIV_W   = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int PRE_W   = (ADC_RATIO > 1) ? $clog2(ADC_RATIO) : 1;
  localparam int MAXWAIT = (RESET_WAIT > DECODE_WAIT) ? RESET_WAIT : DECODE_WAIT;
  localparam int CYC_W   = $clog2(MAXWAIT + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(ADC_RATIO - 1);
  localparam logic [CYC_W-1:0] DEC_LAST = CYC_W'(DECODE_WAIT - 1);
  localparam logic [CYC_W-1:0] RST_LAST = CYC_W'(RESET_WAIT - 1);

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh, rxSh;
  logic             byteDoneR;
  logic             waiting, waitLongQ, waitDoneR;
  logic [PRE_W-1:0] preCnt;
  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] cycLast;

  // chip-select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csN <= 1'b1;
    else if (strb.csAssert) csN <= 1'b0;
    else if (strb.csRelease) csN <= 1'b1;
  end

  // byte shifter, mode 1: launch on rise, capture on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; divCnt <= '0; bitCnt <= '0; sclk <= 1'b0;
      txSh <= '0; rxSh <= '0; mosi <= 1'b0; byteDoneR <= 1'b0;
    end else begin
      byteDoneR <= 1'b0;
      if (strb.loadByte) begin
        active <= 1'b1; txSh <= strb.txByte; divCnt <= '0;
        bitCnt <= '0; sclk <= 1'b0;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            mosi <= txSh[7];
          end else begin
            sclk   <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            rxSh   <= {rxSh[6:0], miso};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active    <= 1'b0;
              byteDoneR <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // pause counter in converter clock periods
  assign cycLast = waitLongQ ? RST_LAST : DEC_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waiting <= 1'b0; waitLongQ <= 1'b0; waitDoneR <= 1'b0;
      preCnt <= '0; cycCnt <= '0;
    end else begin
      waitDoneR <= 1'b0;
      if (strb.waitStart) begin
        waiting <= 1'b1; waitLongQ <= strb.waitLong;
        preCnt <= '0; cycCnt <= '0;
      end else if (waiting) begin
        if (preCnt == PRE_LAST) begin
          preCnt <= '0;
          if (cycCnt == cycLast) begin
            waiting   <= 1'b0;
            waitDoneR <= 1'b1;
          end else begin
            cycCnt <= cycCnt + CYC_W'(1);
          end
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  end

  assign dpStat.byteDone = byteDoneR;
  assign dpStat.waitDone = waitDoneR;
  assign dpStat.rxByte   = rxSh;

  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  a_r6_cs_low_while_shifting: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !csN);
  a_r4_no_shift_during_pause: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> !active);

endmodule

// File: rtl/spi_adc_cmd_ctrl.sv
module spi_adc_cmd_ctrl
  import spi_adc_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [7:0]            reqCmd,
  input  logic [REG_ADDR_W-1:0] reqAddr,
  input  logic [7:0]            reqWrData,
  input  dpStatus_t             dpStat,
  output ctrlStrobe_t           strb,
  output logic                  busy,
  output logic                  done,
  output logic [7:0]            rdData
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SHIFT, S_DECWAIT, S_RELEASE, S_RSTWAIT, S_DONE
  } state_t;

  state_t     state, stateNext;
  reqKind_t   kindQ;
  logic [7:0] opcodeQ, wrDataQ;
  logic       isResetQ;
  logic [1:0] byteIdx, lastIdx;
  logic       accept;

  assign accept  = (state == S_IDLE) && reqValid && (reqKind != KIND_NONE);
  assign lastIdx = (kindQ == KIND_CMD) ? 2'd0 : 2'd2;

  always_comb begin
    stateNext = state;
    strb = '0;
    case (byteIdx)
      2'd0:    strb.txByte = opcodeQ;
      2'd1:    strb.txByte = 8'h00;
      default: strb.txByte = (kindQ == KIND_WRITE) ? wrDataQ : 8'h00;
    endcase
    case (state)
      S_IDLE: if (accept) begin
        strb.csAssert = 1'b1;
        stateNext = S_LOAD;
      end
      S_LOAD: begin
        strb.loadByte = 1'b1;
        stateNext = S_SHIFT;
      end
      S_SHIFT: if (dpStat.byteDone) begin
        if (byteIdx == lastIdx) begin
          strb.csRelease = 1'b1;
          stateNext = S_RELEASE;
        end else if (byteIdx == 2'd1) begin
          strb.waitStart = 1'b1;
          stateNext = S_DECWAIT;
        end else begin
          stateNext = S_LOAD;
        end
      end
      S_DECWAIT: if (dpStat.waitDone) stateNext = S_LOAD;
      S_RELEASE: begin
        if (isResetQ) begin
          strb.waitStart = 1'b1;
          strb.waitLong  = 1'b1;
          stateNext = S_RSTWAIT;
        end else begin
          stateNext = S_DONE;
        end
      end
      S_RSTWAIT: if (dpStat.waitDone) stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; kindQ <= KIND_CMD; opcodeQ <= '0; wrDataQ <= '0;
      isResetQ <= 1'b0; byteIdx <= '0; rdData <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        kindQ    <= reqKind_t'(reqKind);
        wrDataQ  <= reqWrData;
        byteIdx  <= '0;
        isResetQ <= (reqKind == KIND_CMD) && (reqCmd == RESET_OPCODE);
        case (reqKind)
          KIND_READ:  opcodeQ <= {READ_PREFIX, reqAddr};
          KIND_WRITE: opcodeQ <= {WRITE_PREFIX, reqAddr};
          default:    opcodeQ <= reqCmd;
        endcase
      end else if (state == S_SHIFT && dpStat.byteDone) begin
        byteIdx <= byteIdx + 2'd1;
        if (kindQ == KIND_READ && byteIdx == 2'd2) rdData <= dpStat.rxByte;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> ($stable(opcodeQ) && $stable(wrDataQ) && $stable(kindQ)));
  a_r7_done_returns_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |=> (state == S_IDLE));

endmodule

// File: rtl/spi_adc_cmd_engine.sv
module spi_adc_cmd_engine
  import spi_adc_cmd_pkg::*;
#(
  parameter int SCLK_HALF   = 2,
  parameter int ADC_RATIO   = 3,
  parameter int DECODE_WAIT = 4,
  parameter int RESET_WAIT  = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic [7:0] reqCmd,
  input  logic [4:0] reqAddr,
  input  logic [7:0] reqWrData,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       csN,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);

  ctrlStrobe_t strb;
  dpStatus_t   dpStat;

  spi_adc_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .dpStat(dpStat), .strb(strb), .busy(busy), .done(done), .rdData(rdData)
  );

  spi_adc_cmd_dp #(
    .SCLK_HALF(SCLK_HALF), .ADC_RATIO(ADC_RATIO),
    .DECODE_WAIT(DECODE_WAIT), .RESET_WAIT(RESET_WAIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dpStat(dpStat),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  a_r6_cs_high_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: tb/spi_adc_cmd_engine_tb.sv
module spi_adc_cmd_engine_tb_top;

  localparam int RATIO = 3;
  localparam int DEC_MIN = 4 * RATIO;
  localparam int RST_MIN = 18 * RATIO;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic [7:0] reqCmd = 8'h00;
  logic [4:0] reqAddr = 5'h00;
  logic [7:0] reqWrData = 8'h00;
  logic busy, done, csN, sclk, mosi;
  logic miso = 1'b0;
  logic [7:0] rdData;

  always #4 clk = ~clk;

  spi_adc_cmd_engine #(.SCLK_HALF(2), .ADC_RATIO(RATIO)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .busy(busy), .done(done), .rdData(rdData),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails = 0;

  // SPI slave model and monitor, all sampled at falling clk edges
  int cyc = 0;
  int frameCount = 0, frameLen = 0, doneCount = 0;
  int tCsRise = 0, tDone = 0;
  int sclkBad = 0, doneBusyBad = 0;
  int byteIdx = 0, bitIdx = 0;
  int tRise [0:7];
  int tFall [0:7];
  logic [7:0] seen [0:7];
  logic [7:0] respByte = 8'h00;
  logic [7:0] slaveByte = 8'h00;
  logic [7:0] cur = 8'h00;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevDone = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prevCs && !csN) begin byteIdx = 0; bitIdx = 0; end
    if (!prevCs && csN) begin frameCount++; frameLen = byteIdx; tCsRise = cyc; end
    if (!prevSclk && sclk) begin
      if (bitIdx == 0 && byteIdx < 8) begin
        tRise[byteIdx] = cyc;
        slaveByte = (byteIdx == 2) ? respByte : 8'h00;
      end
      miso = slaveByte[7 - bitIdx];
    end
    if (prevSclk && !sclk) begin
      cur = {cur[6:0], mosi};
      bitIdx++;
      if (bitIdx == 8) begin
        if (byteIdx < 8) begin seen[byteIdx] = cur; tFall[byteIdx] = cyc; end
        byteIdx++;
        bitIdx = 0;
      end
    end
    if (csN && sclk) sclkBad++;
    if (prevDone && busy) doneBusyBad++;
    if (done) begin doneCount++; tDone = cyc; end
    prevCs = csN; prevSclk = sclk; prevDone = done;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] c,
                       input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqCmd = c; reqAddr = a; reqWrData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input int startCount);
    for (int i = 0; i < 3000; i++) begin
      if (doneCount > startCount) break;
      @(negedge clk);
    end
    check(doneCount > startCount, "R7 done seen", doneCount, startCount + 1);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    check(csN == 1'b1, "R10 csN", csN, 1);
    check(sclk == 1'b0, "R10 sclk", sclk, 0);
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(done == 1'b0, "R10 done", done, 0);
  endtask

  task automatic t_command(input logic [7:0] c);
    int f0 = frameCount;
    int d0 = doneCount;
    issue(2'b00, c, 5'h00, 8'h00);
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    waitDone(d0);
    check(frameCount == f0 + 1, "R1 one frame", frameCount, f0 + 1);
    check(frameLen == 1, "R1 frame length", frameLen, 1);
    check(seen[0] == c, "R1 command byte", seen[0], c);
    check(tDone > tCsRise, "R6 cs high before done", tDone, tCsRise + 1);
    check(busy == 1'b0, "R7 busy low after done", busy, 0);
    if (c == 8'h06)
      check(tDone - tCsRise >= RST_MIN, "R5 reset recovery", tDone - tCsRise, RST_MIN);
    else
      check(tDone - tCsRise < RST_MIN, "R9 no recovery wait", tDone - tCsRise, RST_MIN - 1);
  endtask

  task automatic t_read(input logic [4:0] a, input logic [7:0] resp);
    int f0 = frameCount;
    int d0 = doneCount;
    respByte = resp;
    issue(2'b01, 8'h00, a, 8'h00);
    waitDone(d0);
    check(frameCount == f0 + 1 && frameLen == 3, "R2 frame length", frameLen, 3);
    check(seen[0] == (8'h20 | {3'b000, a}), "R2 read opcode", seen[0], 8'h20 | {3'b000, a});
    check(seen[1] == 8'h00, "R2 count byte", seen[1], 0);
    check(rdData == resp, "R2 read data", rdData, resp);
    check(tRise[2] - tFall[1] >= DEC_MIN, "R4 decode pause", tRise[2] - tFall[1], DEC_MIN);
  endtask

  task automatic t_write(input logic [4:0] a, input logic [7:0] v);
    int f0 = frameCount;
    int d0 = doneCount;
    respByte = 8'h00;
    issue(2'b10, 8'h00, a, v);
    waitDone(d0);
    check(frameCount == f0 + 1 && frameLen == 3, "R3 frame length", frameLen, 3);
    check(seen[0] == (8'h40 | {3'b000, a}), "R3 write opcode", seen[0], 8'h40 | {3'b000, a});
    check(seen[1] == 8'h00, "R3 count byte", seen[1], 0);
    check(seen[2] == v, "R3 value byte", seen[2], v);
    check(tRise[2] - tFall[1] >= DEC_MIN, "R4 decode pause", tRise[2] - tFall[1], DEC_MIN);
  endtask

  task automatic t_busy_ignore;
    int f0 = frameCount;
    int d0 = doneCount;
    issue(2'b10, 8'h00, 5'h03, 8'h5A);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqKind = 2'b01; reqAddr = 5'h07;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(d0);
    repeat (300) @(negedge clk);
    check(frameCount == f0 + 1, "R8 mid-frame request ignored", frameCount, f0 + 1);
    check(seen[0] == 8'h43, "R8 opcode untouched", seen[0], 8'h43);
    check(seen[2] == 8'h5A, "R8 value untouched", seen[2], 8'h5A);
  endtask

  task automatic t_done_collision;
    int f0 = frameCount;
    issue(2'b00, 8'h0A, 5'h00, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    check(done == 1'b1, "R8 done reached", done, 1);
    reqValid = 1'b1; reqKind = 2'b01; reqAddr = 5'h02;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (300) @(negedge clk);
    check(frameCount == f0 + 1, "R8 request at done ignored", frameCount, f0 + 1);
    check(busy == 1'b0, "R8 idle after collision", busy, 0);
  endtask

  task automatic t_kind_none;
    int f0 = frameCount;
    issue(2'b11, 8'h08, 5'h01, 8'h00);
    check(busy == 1'b0, "R11 busy stays low", busy, 0);
    repeat (300) @(negedge clk);
    check(frameCount == f0, "R11 no frame", frameCount, f0);
    check(csN == 1'b1, "R11 cs idle", csN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_command(8'h08);
    t_command(8'h11);
    t_read(5'h05, 8'h3C);
    t_read(5'h1F, 8'hC3);
    t_write(5'h01, 8'h96);
    t_write(5'h1F, 8'hFF);
    t_command(8'h06);
    t_command(8'h1A);
    t_busy_ignore();
    t_done_collision();
    t_kind_none();
    check(sclkBad == 0, "R6 sclk low while cs high", sclkBad, 0);
    check(doneBusyBad == 0, "R7 busy low after done", doneBusyBad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule